// File: doc/BRIEF.md
# Transaction-Layer Flit Packer

This block gathers a stream of control messages and data payloads into fixed 64-byte flits. Each flit is made of sixteen 32-bit sectors and splits into a lower half (sectors 0 to 7) and an upper half (sectors 8 to 15). Each half is either a control half or a data half. Control messages are requests and responses, each of them compressed or uncompressed. They take one to four sectors and are packed one after another into control halves, whatever their destinations. Sectors left unused are NOP sectors. A NOP sector is all zeros.

A message that carries a payload says how many data half-flits follow it. The packer closes the control half that holds the message. The payload beats then take the half right after it, or a whole flit when the payload is 64 bytes. A partly filled flit is padded and sent once the message input has been quiet for a programmable number of cycles. Back-pressure on the flit output stops both input lanes, so messages are never dropped and leave in arrival order.

Top module: `tl_flit_packer`

## Requirements
- R1: After reset, flit_valid is low, msg_ready is high, dat_ready is low, and the first flit starts empty.
- R2: msg_kind sets the sector count of a message: 0 = uncompressed request (4), 1 = compressed request (2), 2 = uncompressed response (2), 3 = compressed response (1). Message sector i is msg_body[32i+31:32i]. It lands in the next free sector of the current control half. Flit sector k is flit_data[32k+31:32k].
- R3: A message that does not fit in the sectors left in the current control half starts at the first sector of the next half. The skipped sectors stay NOP (all zero).
- R4: A flit is offered on flit_valid as soon as both of its halves are closed. Its flit_kind is 0 for two control halves.
- R5: A non-empty flit is padded with NOP and offered after cfg_idle_limit consecutive cycles with msg_valid low. A limit of 0 acts as 1. An empty flit is never offered.
- R6: msg_dhalves = 1 closes the message's control half. The next dat_half beat fills the following half: the upper half of the same flit, or the lower half of the next one. That half's flit_kind bit is set (bit 0 lower, bit 1 upper, 1 = data).
- R7: msg_dhalves of 2 or 3 sends the current flit with its remaining halves as NOP control. The next two beats form one full data flit (lower, then upper) with flit_kind = 3.
- R8: While flit_valid is high and flit_ready is low, flit_data and flit_kind hold steady. While flit_valid is high, msg_ready and dat_ready stay low.
- R9: While data beats are owed, msg_ready is low, dat_ready is high, and no idle flush happens. dat_ready is low at all other times.
- R10: Messages appear in the flits in their exact acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idle_limit | input | 8 | Quiet cycles before a partial flit is flushed |
| msg_valid | input | 1 | Control message offered |
| msg_ready | output | 1 | Control message accepted this cycle |
| msg_kind | input | 2 | Message type and size code |
| msg_dhalves | input | 2 | Data half-flits that follow (0, 1, 2 or more = full flit) |
| msg_body | input | 128 | Message content, up to four sectors |
| dat_valid | input | 1 | Data beat offered |
| dat_ready | output | 1 | Data beat accepted this cycle |
| dat_half | input | 256 | One 32-byte data beat |
| flit_valid | output | 1 | Flit offered |
| flit_ready | input | 1 | Flit taken |
| flit_data | output | 512 | Flit content, sector k at bits 32k+31:32k |
| flit_kind | output | 2 | Per-half kind, bit 0 lower, bit 1 upper, 1 = data |

## Verification
On every cycle, the assertions check the handshake rules. A stalled flit must hold still, and neither input lane may be accepted while a flit is pending. The message lane and data lane must never be open together, and the message lane must close once a message has promised data. Exact sector placement, NOP padding at a half boundary, the idle flush count and the position of data halves next to their control half are shown only by the bench scenarios. Those scenarios compare whole captured flits against layouts worked out from the requirements.

// File: rtl/tl_flit_pkg.sv
package tl_flit_pkg;

    localparam int MSG_SECTORS = 4;
    localparam int NEED_W      = 3;

    typedef enum logic [1:0] {
        MK_REQ_FULL = 2'd0,
        MK_REQ_CMP  = 2'd1,
        MK_RSP_FULL = 2'd2,
        MK_RSP_CMP  = 2'd3
    } msg_kind_e;

    typedef enum logic {
        PH_CTRL = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    function automatic logic [NEED_W-1:0] sectors_of(input msg_kind_e k);
        case (k)
            MK_REQ_FULL: sectors_of = 3'd4;
            MK_REQ_CMP:  sectors_of = 3'd2;
            MK_RSP_FULL: sectors_of = 3'd2;
            default:     sectors_of = 3'd1;
        endcase
    endfunction

    function automatic logic [1:0] data_halves(input logic [1:0] code);
        data_halves = code[1] ? 2'd2 : {1'b0, code[0]};
    endfunction

endpackage

// File: rtl/tl_msg_slot.sv
module tl_msg_slot
    import tl_flit_pkg::*;
#(
    parameter int HALF_SECTORS = 8,
    localparam int FILL_W = $clog2(HALF_SECTORS + 1)
) (
    input  msg_kind_e         kind,
    input  logic [FILL_W-1:0] fill,
    output logic [NEED_W-1:0] need,
    output logic              fits
);
    logic [FILL_W:0] total;

    always_comb begin
        need  = sectors_of(kind);
        total = {1'b0, fill} + (FILL_W + 1)'(need);
        fits  = (total <= (FILL_W + 1)'(HALF_SECTORS));
    end
endmodule

// File: rtl/tl_idle_timer.sv
module tl_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   eff_limit;
    logic [CNT_W:0]   next_cnt;

    always_comb begin
        eff_limit = (limit == '0) ? (CNT_W + 1)'(1) : {1'b0, limit};
        next_cnt  = {1'b0, cnt_q} + (CNT_W + 1)'(1);
        expire    = tick && (next_cnt >= eff_limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick && !expire) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tl_sector_merge.sv
module tl_sector_merge
    import tl_flit_pkg::*;
#(
    parameter int SECTOR_W     = 32,
    parameter int FLIT_SECTORS = 16,
    localparam int IDX_W = $clog2(FLIT_SECTORS)
) (
    input  logic [FLIT_SECTORS-1:0][SECTOR_W-1:0] cur,
    input  logic [IDX_W-1:0]                      base,
    input  logic [NEED_W-1:0]                     count,
    input  logic [MSG_SECTORS*SECTOR_W-1:0]       body,
    output logic [FLIT_SECTORS-1:0][SECTOR_W-1:0] nxt
);
    function automatic logic [SECTOR_W-1:0] pick(input int k);
        pick = cur[k];
        for (int j = 0; j < MSG_SECTORS; j++) begin
            if (j < int'(count) && int'(base) + j == k) begin
                pick = body[j*SECTOR_W +: SECTOR_W];
            end
        end
    endfunction

    for (genvar k = 0; k < FLIT_SECTORS; k++) begin : g_sector
        assign nxt[k] = pick(k);
    end
endmodule

// File: rtl/tl_flit_packer.sv
module tl_flit_packer
    import tl_flit_pkg::*;
#(
    parameter int SECTOR_W     = 32,
    parameter int FLIT_SECTORS = 16,
    parameter int CNT_W        = 8,
    localparam int HALF_SECTORS = FLIT_SECTORS / 2,
    localparam int FLIT_W       = FLIT_SECTORS * SECTOR_W,
    localparam int HALF_W       = HALF_SECTORS * SECTOR_W,
    localparam int MSG_W        = MSG_SECTORS * SECTOR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_idle_limit,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [1:0]        msg_kind,
    input  logic [1:0]        msg_dhalves,
    input  logic [MSG_W-1:0]  msg_body,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [HALF_W-1:0] dat_half,
    output logic              flit_valid,
    input  logic              flit_ready,
    output logic [FLIT_W-1:0] flit_data,
    output logic [1:0]        flit_kind
);
    localparam int FILL_W = $clog2(HALF_SECTORS + 1);
    localparam int IDX_W  = $clog2(FLIT_SECTORS);

    logic [FLIT_SECTORS-1:0][SECTOR_W-1:0] flit_q, merged;
    logic [1:0]        kind_q;
    logic              hsel_q;
    logic [FILL_W-1:0] fill_q;
    logic              out_v_q;
    phase_e            phase_q;
    logic [1:0]        dleft_q;

    logic [NEED_W-1:0] need;
    logic              fits;
    logic [IDX_W-1:0]  base;
    logic [1:0]        dh_n;
    logic              accept, nonempty, tick, expire, emit;

    tl_msg_slot #(.HALF_SECTORS(HALF_SECTORS)) u_slot (
        .kind (msg_kind_e'(msg_kind)),
        .fill (fill_q),
        .need (need),
        .fits (fits)
    );

    tl_sector_merge #(.SECTOR_W(SECTOR_W), .FLIT_SECTORS(FLIT_SECTORS)) u_merge (
        .cur   (flit_q),
        .base  (base),
        .count (need),
        .body  (msg_body),
        .nxt   (merged)
    );

    tl_idle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept || emit),
        .tick   (tick),
        .limit  (cfg_idle_limit),
        .expire (expire)
    );

    always_comb begin
        base      = IDX_W'(fill_q) + (hsel_q ? IDX_W'(HALF_SECTORS) : IDX_W'(0));
        dh_n      = data_halves(msg_dhalves);
        msg_ready = !out_v_q && (phase_q == PH_CTRL) && fits;
        dat_ready = !out_v_q && (phase_q == PH_DATA);
        accept    = msg_valid && msg_ready;
        emit      = out_v_q && flit_ready;
        nonempty  = hsel_q || (fill_q != '0);
        tick      = (phase_q == PH_CTRL) && !out_v_q && nonempty && !msg_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flit_q  <= '0;
            kind_q  <= '0;
            hsel_q  <= 1'b0;
            fill_q  <= '0;
            out_v_q <= 1'b0;
            phase_q <= PH_CTRL;
            dleft_q <= '0;
        end else if (out_v_q) begin
            if (flit_ready) begin
                flit_q  <= '0;
                kind_q  <= '0;
                hsel_q  <= 1'b0;
                fill_q  <= '0;
                out_v_q <= 1'b0;
            end
        end else if (phase_q == PH_CTRL) begin
            if (msg_valid) begin
                if (fits) begin
                    flit_q <= merged;
                    fill_q <= fill_q + FILL_W'(need);
                    if (dh_n != 2'd0) begin
                        phase_q <= PH_DATA;
                        dleft_q <= dh_n;
                        if (!hsel_q && dh_n == 2'd1) begin
                            hsel_q <= 1'b1;
                            fill_q <= '0;
                        end else begin
                            out_v_q <= 1'b1;
                        end
                    end
                end else if (!hsel_q) begin
                    hsel_q <= 1'b1;
                    fill_q <= '0;
                end else begin
                    out_v_q <= 1'b1;
                end
            end else if (expire) begin
                out_v_q <= 1'b1;
            end
        end else if (dat_valid) begin
            if (hsel_q) flit_q[FLIT_SECTORS-1:HALF_SECTORS] <= dat_half;
            else        flit_q[HALF_SECTORS-1:0]            <= dat_half;
            kind_q[hsel_q] <= 1'b1;
            dleft_q        <= dleft_q - 2'd1;
            if (dleft_q == 2'd1) phase_q <= PH_CTRL;
            if (hsel_q) begin
                out_v_q <= 1'b1;
            end else begin
                hsel_q <= 1'b1;
                fill_q <= '0;
            end
        end
    end

    assign flit_valid = out_v_q;
    assign flit_data  = flit_q;
    assign flit_kind  = kind_q;
endmodule

// File: rtl/tl_flit_packer_chk.sv
module tl_flit_packer_chk #(
    parameter int FLIT_W = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [1:0]        msg_dhalves,
    input logic              dat_ready,
    input logic              flit_valid,
    input logic              flit_ready,
    input logic [FLIT_W-1:0] flit_data,
    input logic [1:0]        flit_kind
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !flit_valid && msg_ready && !dat_ready);

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
        flit_valid && !flit_ready |=> flit_valid && $stable(flit_data) && $stable(flit_kind));

    assert_no_accept_pending_R8: assert property (@(posedge clk) disable iff (rst)
        flit_valid |-> !msg_ready && !dat_ready);

    assert_lanes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(msg_ready && dat_ready));

    assert_data_owed_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready && msg_dhalves != 2'd0 |=> !msg_ready);
endmodule

bind tl_flit_packer tl_flit_packer_chk #(.FLIT_W(FLIT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_dhalves (msg_dhalves),
    .dat_ready   (dat_ready),
    .flit_valid  (flit_valid),
    .flit_ready  (flit_ready),
    .flit_data   (flit_data),
    .flit_kind   (flit_kind)
);

// File: tb/tl_flit_packer_test.sv
`timescale 1ns/1ps
module tl_flit_packer_test;
    logic         clk = 1'b0;
    logic         rst;
    logic [7:0]   cfg_idle_limit;
    logic         msg_valid, msg_ready;
    logic [1:0]   msg_kind, msg_dhalves;
    logic [127:0] msg_body;
    logic         dat_valid, dat_ready;
    logic [255:0] dat_half;
    logic         flit_valid, flit_ready;
    logic [511:0] flit_data;
    logic [1:0]   flit_kind;

    always #2.5 clk = ~clk;

    tl_flit_packer uut (.*);

    int n_chk = 0, n_fail = 0, ncap = 0;
    bit done = 0;
    logic [511:0] cap_data [0:63];
    logic [1:0]   cap_kind [0:63];
    logic [15:0][31:0] exp_f;
    logic [1:0]   exp_k;

    always @(negedge clk) begin
        #1;
        if (!rst && flit_valid && flit_ready && ncap < 64) begin
            cap_data[ncap] = flit_data;
            cap_kind[ncap] = flit_kind;
            ncap++;
        end
    end

    function automatic logic [127:0] mkbody(input logic [23:0] tag);
        logic [127:0] b;
        for (int i = 0; i < 4; i++) b[i*32 +: 32] = {tag, 8'(i)};
        return b;
    endfunction

    function automatic logic [255:0] mkhalf(input logic [23:0] tag);
        logic [255:0] b;
        for (int i = 0; i < 8; i++) b[i*32 +: 32] = {tag, 8'(i)};
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic exp_clear();
        exp_f = '0;
        exp_k = 2'd0;
    endtask

    task automatic exp_msg(input int pos, input logic [23:0] tag, input int n);
        for (int i = 0; i < n; i++) exp_f[pos+i] = {tag, 8'(i)};
    endtask

    task automatic exp_data(input int h, input logic [23:0] tag);
        for (int i = 0; i < 8; i++) exp_f[h*8+i] = {tag, 8'(i)};
        exp_k[h] = 1'b1;
    endtask

    task automatic check_flit(input int idx, input string req);
        if (idx >= ncap) begin
            check(0, req, "flit missing", 512'(ncap), 512'(idx + 1));
        end else begin
            check(cap_data[idx] === exp_f, req, "flit data", cap_data[idx], exp_f);
            check(cap_kind[idx] === exp_k, req, "flit kind", 512'(cap_kind[idx]), 512'(exp_k));
        end
    endtask

    task automatic send_msg(input logic [1:0] k, input logic [23:0] tag, input logic [1:0] dh);
        msg_kind = k; msg_body = mkbody(tag); msg_dhalves = dh; msg_valid = 1'b1;
        #1;
        while (!msg_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic send_dat(input logic [23:0] tag);
        dat_half = mkhalf(tag); dat_valid = 1'b1;
        #1;
        while (!dat_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic wait_caps(input int n);
        int k = 0;
        while (ncap < n && k < 300) begin @(negedge clk); #2; k++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check(flit_valid == 1'b0, "R1", "flit_valid after reset", 512'(flit_valid), 512'(0));
        check(msg_ready == 1'b1, "R1", "msg_ready after reset", 512'(msg_ready), 512'(1));
        check(dat_ready == 1'b0, "R1", "dat_ready after reset", 512'(dat_ready), 512'(0));
        @(negedge clk);
    endtask

    task automatic t_mixed_fill();
        int b = ncap;
        send_msg(2'd0, 24'd1, 2'd0);
        send_msg(2'd1, 24'd2, 2'd0);
        send_msg(2'd2, 24'd3, 2'd0);
        send_msg(2'd3, 24'd4, 2'd0);
        send_msg(2'd0, 24'd5, 2'd0);
        send_msg(2'd1, 24'd6, 2'd0);
        send_msg(2'd3, 24'd7, 2'd0);
        send_msg(2'd3, 24'd8, 2'd0);
        wait_caps(b + 2);
        exp_clear();
        exp_msg(0, 24'd1, 4); exp_msg(4, 24'd2, 2); exp_msg(6, 24'd3, 2);
        exp_msg(8, 24'd4, 1); exp_msg(9, 24'd5, 4); exp_msg(13, 24'd6, 2); exp_msg(15, 24'd7, 1);
        check_flit(b, "R2 R4 R10 mixed sizes in order");
        exp_clear();
        exp_msg(0, 24'd8, 1);
        check_flit(b + 1, "R5 leftover flushed");
    endtask

    task automatic t_half_boundary();
        int b = ncap;
        send_msg(2'd3, 24'd9, 2'd0);
        send_msg(2'd0, 24'd10, 2'd0);
        send_msg(2'd0, 24'd11, 2'd0);
        wait_caps(b + 1);
        exp_clear();
        exp_msg(0, 24'd9, 1); exp_msg(1, 24'd10, 4); exp_msg(8, 24'd11, 4);
        check_flit(b, "R3 NOP pad at half boundary");
    endtask

    task automatic t_idle(input logic [7:0] lim, input int expect_n);
        int b = ncap;
        int n = 0;
        cfg_idle_limit = lim;
        send_msg(2'd3, 24'd30, 2'd0);
        #1;
        check(flit_valid == 1'b0, "R5", "flit_valid right after message", 512'(flit_valid), 512'(0));
        while (n < 300) begin
            @(negedge clk); #1; n++;
            if (flit_valid) break;
        end
        check(n == expect_n, "R5", "idle cycles before flush", 512'(n), 512'(expect_n));
        wait_caps(b + 1);
        exp_clear();
        exp_msg(0, 24'd30, 1);
        check_flit(b, "R5 idle flushed flit");
        cfg_idle_limit = 8'd8;
    endtask

    task automatic t_data_upper();
        int b = ncap;
        send_msg(2'd1, 24'd40, 2'd1);
        #1;
        check(msg_ready == 1'b0, "R9", "msg_ready while data owed", 512'(msg_ready), 512'(0));
        check(dat_ready == 1'b1, "R9", "dat_ready while data owed", 512'(dat_ready), 512'(1));
        repeat (12) @(negedge clk);
        #1;
        check(flit_valid == 1'b0, "R9", "no flush while data owed", 512'(flit_valid), 512'(0));
        @(negedge clk);
        send_dat(24'd41);
        wait_caps(b + 1);
        exp_clear();
        exp_msg(0, 24'd40, 2); exp_data(1, 24'd41);
        check_flit(b, "R6 data in upper half");
        #1;
        check(dat_ready == 1'b0, "R9", "dat_ready after data done", 512'(dat_ready), 512'(0));
        @(negedge clk);
    endtask

    task automatic t_data_lower();
        int b = ncap;
        send_msg(2'd0, 24'd50, 2'd0);
        send_msg(2'd0, 24'd51, 2'd0);
        send_msg(2'd3, 24'd52, 2'd1);
        send_dat(24'd53);
        wait_caps(b + 2);
        exp_clear();
        exp_msg(0, 24'd50, 4); exp_msg(4, 24'd51, 4); exp_msg(8, 24'd52, 1);
        check_flit(b, "R6 control flit before data");
        exp_clear();
        exp_data(0, 24'd53);
        check_flit(b + 1, "R6 data in lower half of next flit");
    endtask

    task automatic t_data_full();
        int b = ncap;
        send_msg(2'd1, 24'd60, 2'd2);
        send_dat(24'd61);
        send_dat(24'd62);
        wait_caps(b + 2);
        exp_clear();
        exp_msg(0, 24'd60, 2);
        check_flit(b, "R7 control flit padded");
        exp_clear();
        exp_data(0, 24'd61); exp_data(1, 24'd62);
        check_flit(b + 1, "R7 full data flit");
    endtask

    task automatic t_backpressure();
        int b = ncap;
        bit stall_ok = 1'b1;
        flit_ready = 1'b0;
        send_msg(2'd0, 24'd20, 2'd0);
        send_msg(2'd0, 24'd21, 2'd0);
        send_msg(2'd0, 24'd22, 2'd0);
        send_msg(2'd0, 24'd23, 2'd0);
        exp_clear();
        exp_msg(0, 24'd20, 4); exp_msg(4, 24'd21, 4); exp_msg(8, 24'd22, 4); exp_msg(12, 24'd23, 4);
        fork
            send_msg(2'd3, 24'd24, 2'd0);
            begin
                repeat (4) begin
                    @(negedge clk); #1;
                    if (!flit_valid || msg_ready || dat_ready || flit_data !== exp_f) stall_ok = 1'b0;
                end
                check(stall_ok, "R8", "flit held and inputs blocked while stalled",
                      512'(stall_ok), 512'(1));
                @(negedge clk);
                flit_ready = 1'b1;
            end
        join
        wait_caps(b + 2);
        check_flit(b, "R8 stalled flit delivered intact");
        exp_clear();
        exp_msg(0, 24'd24, 1);
        check_flit(b + 1, "R10 held message follows");
    endtask

    task automatic t_empty();
        int b = ncap;
        repeat (30) @(negedge clk);
        check(ncap == b, "R5", "no empty flit emitted", 512'(ncap), 512'(b));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cfg_idle_limit = 8'd8;
        msg_valid = 1'b0; msg_kind = '0; msg_dhalves = '0; msg_body = '0;
        dat_valid = 1'b0; dat_half = '0; flit_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mixed_fill();
        t_half_boundary();
        t_idle(8'd8, 8);
        t_idle(8'd3, 3);
        t_idle(8'd0, 1);
        t_data_upper();
        t_data_lower();
        t_data_full();
        t_backpressure();
        t_empty();
        done = 1'b1;
        finish_run();
    end
endmodule